// File: doc/BRIEF.md
# Prioritised Two-Level Interrupt Controller

This block gathers up to `NSRC` level-type interrupt inputs and drives two request lines toward a processor: a normal request and a fast request. Each source first passes a shared input stage. That stage corrects the polarity and offers either the live level or an edge-captured latched bit. Two identical request channels then apply their own enable set and their own priority threshold. The channels share one table of per-source 3-bit priorities, where a smaller number is more urgent.

Software uses a word-addressed register port. A handler reads the acknowledge register of a channel to learn which source to serve. That read also saves the channel's threshold and raises it to the priority of the source just taken, so only more urgent sources can interrupt the handler. When the handler reads the end register, the saved threshold comes back. One saved level is kept per channel.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, both enable sets, all latched bits, all source-select bits and all priorities are 0. The polarity register (word address 0x10) reads all ones. Both thresholds (channel offset +7) read 8. Both request outputs are low.
- R2: A polarity bit of 0 inverts the matching input. The status view (channel offset +1) shows the polarity-corrected level for sources whose select bit (word address 0x11) is 0.
- R3: For a source whose select bit is 1, the status view shows a latched bit. That bit sets on a rising edge of the polarity-corrected input and stays set after the input falls. Writing a 1 at offset +1 of either channel clears it.
- R4: Writing 1s at channel offset +2 sets enable bits. Writing 1s at offset +3 clears them. Zero bits leave their enable bits unchanged, and both offsets read back the enable set.
- R5: The masked status (channel offset +0) always equals the status view AND that channel's enable set, with bit n for source n.
- R6: The current source is the enabled, pending source with the smallest priority value, written at word address 0x20+n bits [2:0]. A tie goes to the lower source number. Offset +4 returns it with no side effect, and returns NSRC when the channel has no request.
- R7: A channel's request output is high exactly when its current source's priority is below the channel's 4-bit threshold.
- R8: Reading offset +5 returns the current source and, when a request is present, saves the threshold and loads the source's priority into the threshold. With no request the read changes nothing.
- R9: Reading offset +6 returns the saved threshold and copies it back into the threshold.
- R10: The normal channel sits at base 0x00 and the fast channel at base 0x08. Enable and threshold state of one channel does not affect the other's request output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | NSRC | Interrupt source levels |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, same cycle |
| irq_o | output | 1 | Normal-channel request |
| fiq_o | output | 1 | Fast-channel request |

## Verification
Random rounds set source levels, polarity, enable sets, priorities and thresholds. In each round, the masked status, the current-source readout and both request lines of each channel are compared with a bench model. This separates errors in polarity handling, enable masking, the priority search and the threshold compare. Directed cases cover the rest. A priority tie checks that the lower number wins. A pulse on a latched source checks that the bit holds and clears. An acknowledge followed by an end read checks that the threshold is raised and restored. An acknowledge with nothing pending checks that it has no effect. Differing enable sets show that the two channels are independent.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef logic [2:0] prio_t;
  typedef logic [3:0] thr_t;

  typedef enum logic [2:0] {
    OFS_MASKED = 3'd0,
    OFS_STATUS = 3'd1,
    OFS_EN_SET = 3'd2,
    OFS_EN_CLR = 3'd3,
    OFS_PEEK   = 3'd4,
    OFS_ACK    = 3'd5,
    OFS_END    = 3'd6,
    OFS_THR    = 3'd7
  } ch_ofs_e;

  localparam logic [5:0] ADDR_POL = 6'h10;
  localparam logic [5:0] ADDR_SEL = 6'h11;
  localparam thr_t       THR_RESET = 4'd8;
endpackage

// File: rtl/pic_src_front.sv
module pic_src_front #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] pol,
  input  logic [NSRC-1:0] sel,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] view
);
  logic [NSRC-1:0] lvl_q, lvl_prev_q, sticky_q, sticky_d;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic adj;
    assign adj = src_i[i] ^ ~pol[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q[i]      <= 1'b0;
        lvl_prev_q[i] <= 1'b0;
      end else begin
        lvl_q[i]      <= adj;
        lvl_prev_q[i] <= lvl_q[i];
      end
    end

    always_comb begin
      sticky_d[i] = sticky_q[i];
      if (clr[i]) sticky_d[i] = 1'b0;
      if (lvl_q[i] && !lvl_prev_q[i]) sticky_d[i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sticky_q[i] <= 1'b0;
      else        sticky_q[i] <= sticky_d[i];
    end

    assign view[i] = sel[i] ? sticky_q[i] : lvl_q[i];
  end

  // R3: latched bits only drop when a clear is requested
  a_r3_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clr == '0) |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int NSRC = 32,
  localparam int ID_W = $clog2(NSRC + 1)
) (
  input  logic [NSRC-1:0]      cand,
  input  pic_pkg::prio_t [NSRC-1:0] prio,
  output logic                 found,
  output logic [ID_W-1:0]      best_id,
  output pic_pkg::prio_t       best_p
);
  always_comb begin
    found   = 1'b0;
    best_id = ID_W'(NSRC);
    best_p  = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && (!found || prio[i] < best_p)) begin
        found   = 1'b1;
        best_id = ID_W'(i);
        best_p  = prio[i];
      end
    end
  end
endmodule

// File: rtl/pic_channel.sv
module pic_channel #(
  parameter int NSRC = 32,
  localparam int ID_W = $clog2(NSRC + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       view,
  input  pic_pkg::prio_t [NSRC-1:0] prio,
  input  logic                  en_set_we,
  input  logic                  en_clr_we,
  input  logic                  thr_we,
  input  logic                  ack_rd,
  input  logic                  end_rd,
  input  logic [NSRC-1:0]       wbits,
  input  pic_pkg::thr_t         wthr,
  output logic [NSRC-1:0]       en,
  output logic [NSRC-1:0]       masked,
  output pic_pkg::thr_t         thr,
  output pic_pkg::thr_t         saved,
  output logic [ID_W-1:0]       cur_id,
  output logic                  req
);
  import pic_pkg::*;

  logic [NSRC-1:0] en_q, en_d;
  thr_t            thr_q, thr_d, sav_q, sav_d;
  logic            found;
  logic [ID_W-1:0] best_id;
  prio_t           best_p;

  assign masked = view & en_q;

  pic_arbiter #(.NSRC(NSRC)) u_arb (
    .cand    (masked),
    .prio    (prio),
    .found   (found),
    .best_id (best_id),
    .best_p  (best_p)
  );

  assign req    = found && ({1'b0, best_p} < thr_q);
  assign cur_id = req ? best_id : ID_W'(NSRC);

  always_comb begin
    en_d  = en_q;
    thr_d = thr_q;
    sav_d = sav_q;
    if (en_set_we) en_d = en_d | wbits;
    if (en_clr_we) en_d = en_d & ~wbits;
    if (thr_we) thr_d = wthr;
    if (ack_rd && req) begin
      sav_d = thr_q;
      thr_d = {1'b0, best_p};
    end else if (end_rd) begin
      thr_d = sav_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      thr_q <= THR_RESET;
      sav_q <= THR_RESET;
    end else begin
      en_q  <= en_d;
      thr_q <= thr_d;
      sav_q <= sav_d;
    end
  end

  assign en    = en_q;
  assign thr   = thr_q;
  assign saved = sav_q;

  // R4: a set write leaves every written bit enabled
  a_r4_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    en_set_we |=> ((en_q & $past(wbits)) == $past(wbits)));
  // R7: a request needs at least one enabled pending source
  a_r7_req_needs_src: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (masked != '0));
  // R8: acknowledge saves the old threshold and raises it
  a_r8_ack_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && req) |=> (thr_q == {1'b0, $past(best_p)}) && (sav_q == $past(thr_q)));
  // R9: end read restores the saved threshold
  a_r9_end_restores: assert property (@(posedge clk) disable iff (!rst_n)
    end_rd |=> (thr_q == $past(sav_q)));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [5:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            irq_o,
  output logic            fiq_o
);
  import pic_pkg::*;
  localparam int ID_W = $clog2(NSRC + 1);
  localparam int NCH  = 2;

  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic wr_stb, rd_stb;
  assign wr_stb = bus_sel && bus_wr;
  assign rd_stb = bus_sel && !bus_wr;

  logic [NSRC-1:0] pol_q, pol_d, sel_q, sel_d, view, clr;
  prio_t [NSRC-1:0] prio_q, prio_d;

  logic            ch_hit [NCH];
  logic [NSRC-1:0] ch_en [NCH], ch_masked [NCH];
  thr_t            ch_thr [NCH], ch_sav [NCH];
  logic [ID_W-1:0] ch_cur [NCH];
  logic            ch_req [NCH];
  logic [NSRC-1:0] clr_part [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_hit[c] = (bus_addr[5:4] == 2'b00) && (bus_addr[3] == c[0]);
    assign clr_part[c] = (wr_stb && ch_hit[c] && bus_addr[2:0] == OFS_STATUS)
                         ? bus_wdata[NSRC-1:0] : '0;

    pic_channel #(.NSRC(NSRC)) u_ch (
      .clk       (clk),
      .rst_n     (rst_ni),
      .view      (view),
      .prio      (prio_q),
      .en_set_we (wr_stb && ch_hit[c] && bus_addr[2:0] == OFS_EN_SET),
      .en_clr_we (wr_stb && ch_hit[c] && bus_addr[2:0] == OFS_EN_CLR),
      .thr_we    (wr_stb && ch_hit[c] && bus_addr[2:0] == OFS_THR),
      .ack_rd    (rd_stb && ch_hit[c] && bus_addr[2:0] == OFS_ACK),
      .end_rd    (rd_stb && ch_hit[c] && bus_addr[2:0] == OFS_END),
      .wbits     (bus_wdata[NSRC-1:0]),
      .wthr      (bus_wdata[3:0]),
      .en        (ch_en[c]),
      .masked    (ch_masked[c]),
      .thr       (ch_thr[c]),
      .saved     (ch_sav[c]),
      .cur_id    (ch_cur[c]),
      .req       (ch_req[c])
    );
  end

  assign clr = clr_part[0] | clr_part[1];

  pic_src_front #(.NSRC(NSRC)) u_front (
    .clk   (clk),
    .rst_n (rst_ni),
    .src_i (src_i),
    .pol   (pol_q),
    .sel   (sel_q),
    .clr   (clr),
    .view  (view)
  );

  always_comb begin
    pol_d  = pol_q;
    sel_d  = sel_q;
    prio_d = prio_q;
    if (wr_stb && bus_addr == ADDR_POL) pol_d = bus_wdata[NSRC-1:0];
    if (wr_stb && bus_addr == ADDR_SEL) sel_d = bus_wdata[NSRC-1:0];
    for (int i = 0; i < NSRC; i++) begin
      if (wr_stb && bus_addr[5] && (int'(bus_addr[4:0]) == i))
        prio_d[i] = bus_wdata[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q  <= '1;
      sel_q  <= '0;
      prio_q <= '0;
    end else begin
      pol_q  <= pol_d;
      sel_q  <= sel_d;
      prio_q <= prio_d;
    end
  end

  always_comb begin
    logic c;
    c = bus_addr[3];
    bus_rdata = '0;
    if (bus_addr[5]) begin
      for (int i = 0; i < NSRC; i++)
        if (int'(bus_addr[4:0]) == i) bus_rdata[2:0] = prio_q[i];
    end else if (bus_addr == ADDR_POL) begin
      bus_rdata[NSRC-1:0] = pol_q;
    end else if (bus_addr == ADDR_SEL) begin
      bus_rdata[NSRC-1:0] = sel_q;
    end else if (bus_addr[5:4] == 2'b00) begin
      case (ch_ofs_e'(bus_addr[2:0]))
        OFS_MASKED: bus_rdata[NSRC-1:0] = ch_masked[c];
        OFS_STATUS: bus_rdata[NSRC-1:0] = view;
        OFS_EN_SET,
        OFS_EN_CLR: bus_rdata[NSRC-1:0] = ch_en[c];
        OFS_PEEK,
        OFS_ACK:    bus_rdata[ID_W-1:0] = ch_cur[c];
        OFS_END:    bus_rdata[3:0] = ch_sav[c];
        OFS_THR:    bus_rdata[3:0] = ch_thr[c];
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign irq_o = ch_req[0];
  assign fiq_o = ch_req[1];

  // R5: masked status never shows a disabled source
  a_r5_masked_in_en: assert property (@(posedge clk) disable iff (!rst_ni)
    ((ch_masked[0] & ~ch_en[0]) == '0) && ((ch_masked[1] & ~ch_en[1]) == '0));
  // R1: requests are low in the first cycle after reset release
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(rst_sync_q[1]) |-> (!irq_o && !fiq_o));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int NSRC = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC-1:0] src_i;
  logic            bus_sel, bus_wr;
  logic [5:0]      bus_addr;
  logic [31:0]     bus_wdata, bus_rdata;
  logic            irq_o, fiq_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prio_irq_ctrl #(.NSRC(NSRC)) u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  logic [NSRC-1:0] m_pol;
  logic [NSRC-1:0] m_en [2];
  logic [3:0]      m_thr [2];
  logic [2:0]      m_prio [NSRC];

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_cur(logic [NSRC-1:0] cand, logic [3:0] thr);
    int best = NSRC;
    for (int i = 0; i < NSRC; i++)
      if (cand[i] && (best == NSRC || m_prio[i] < m_prio[best])) best = i;
    if (best == NSRC || {1'b0, m_prio[best]} >= thr) return NSRC;
    return best;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    rst_n = 0; src_i = '0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(6'h10, d); check("R1 polarity", d, 32'hFFFF_FFFF);
    rd(6'h07, d); check("R1 threshold", d, 32'd8);
    rd(6'h0F, d); check("R1 fast threshold", d, 32'd8);
    rd(6'h02, d); check("R1 enables", d, 32'd0);
    rd(6'h25, d); check("R1 priority", d, 32'd0);
    check("R1 irq_o", {31'd0, irq_o}, 32'd0);
    check("R1 fiq_o", {31'd0, fiq_o}, 32'd0);

    // R2 polarity inversion
    wr(6'h10, 32'hFFFF_FFF7);
    settle();
    rd(6'h01, d); check("R2 inverted level", d, 32'h0000_0008);
    wr(6'h10, 32'hFFFF_FFFF);
    settle();
    rd(6'h01, d); check("R2 restored", d, 32'h0);

    // R3 latched bit
    wr(6'h11, 32'h0000_0020);
    src_i[5] = 1; settle();
    src_i[5] = 0; settle();
    rd(6'h01, d); check("R3 latched after pulse", d, 32'h0000_0020);
    wr(6'h09, 32'h0000_0020);
    settle();
    rd(6'h01, d); check("R3 cleared by write", d, 32'h0);
    wr(6'h11, 32'h0);

    // R4 enable set and clear
    wr(6'h02, 32'h0000_000F);
    wr(6'h03, 32'h0000_0005);
    rd(6'h03, d); check("R4 enable set/clear", d, 32'h0000_000A);
    rd(6'h0A, d); check("R10 fast enables untouched", d, 32'h0);

    // R6 tie break and R8/R9 acknowledge
    wr(6'h02, 32'hFFFF_FFFF);
    wr(6'h21, 32'd2); wr(6'h22, 32'd2); wr(6'h20, 32'd5);
    src_i = 32'h7; settle();
    rd(6'h04, d); check("R6 tie goes to lower number", d, 32'd1);
    check("R7 irq_o high", {31'd0, irq_o}, 32'd1);
    check("R10 fiq_o low with no fast enables", {31'd0, fiq_o}, 32'd0);
    rd(6'h05, d); check("R8 ack returns source", d, 32'd1);
    rd(6'h07, d); check("R8 threshold raised", d, 32'd2);
    settle();
    check("R7 irq_o dropped at threshold", {31'd0, irq_o}, 32'd0);
    rd(6'h05, d); check("R8 ack without request", d, NSRC);
    rd(6'h07, d); check("R8 threshold unchanged", d, 32'd2);
    rd(6'h06, d); check("R9 end returns saved", d, 32'd8);
    rd(6'h07, d); check("R9 threshold restored", d, 32'd8);

    // random rounds: R5 R6 R7 R10
    m_prio[0] = 5; m_prio[1] = 2; m_prio[2] = 2;
    for (int i = 3; i < NSRC; i++) m_prio[i] = 0;
    for (int it = 0; it < 120; it++) begin
      m_pol = $urandom;
      for (int c = 0; c < 2; c++) begin
        m_en[c]  = $urandom & $urandom;
        m_thr[c] = 4'($urandom_range(0, 9));
        wr(6'(c * 8 + 3), 32'hFFFF_FFFF);
        wr(6'(c * 8 + 2), m_en[c]);
        wr(6'(c * 8 + 7), {28'd0, m_thr[c]});
      end
      for (int k = 0; k < 4; k++) begin
        int s = $urandom_range(0, NSRC - 1);
        m_prio[s] = 3'($urandom);
        wr(6'(32 + s), {29'd0, m_prio[s]});
      end
      wr(6'h10, m_pol);
      src_i = $urandom;
      settle();
      for (int c = 0; c < 2; c++) begin
        logic [NSRC-1:0] adj, msk;
        logic [31:0] cur;
        adj = src_i ^ ~m_pol;
        msk = adj & m_en[c];
        cur = exp_cur(msk, m_thr[c]);
        rd(6'(c * 8 + 0), d); check("R5 masked status", d, msk);
        rd(6'(c * 8 + 4), d); check("R6 current source", d, cur);
        check("R7 request line", {31'd0, (c == 0) ? irq_o : fiq_o},
              {31'd0, cur != NSRC});
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule